// File: doc/BRIEF.md
# Phase-Lagged PWM Channel Array

This block produces a bank of square waves that share one frequency and a 50% duty cycle. They all come from a single system clock. A master channel runs a free up-counter over a programmable period of T cycles and emits a one-cycle sync pulse each time its count is zero. Every slave channel keeps its own counter. After a fixed latency, the master's sync pulse forces each slave counter to a phase-load value. The block computes that value internally from the requested lag. As a result, each slave output trails the master by an exact whole number of clock cycles.

The lag correction takes the two-cycle sync path into account and wraps the result into the counter range. Software only supplies the lag it wants and never has to deal with the sync latency. The period and the lag set are captured into shadow registers only at the master's period boundary, so reprogramming the block mid-period never produces a short or stretched pulse. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `phased_pwm_array`

## Requirements
- R1: While reset is asserted, or while the enable input is low, every PWM output and the sync output are low. One clock edge after the enable input is sampled high, the master starts at count 0, and the sync output is high in that first running cycle.
- R2: The master counter runs 0, 1, …, T−1 and then wraps to 0. The master output is high while the count is below floor(T/2). A programmed period below 3 is used as 3.
- R3: The sync output is high for exactly one cycle, in each cycle in which the master count is 0, so it pulses once every T cycles.
- R4: Once a slave has been reloaded under an unchanged configuration, its rising edge falls exactly L clock cycles after the master's rising edge, where L is that slave's lag. With L = 0 the two edges coincide. With L = T−1 the slave rises one cycle before the next master rise.
- R5: The slave phase-load value is (T + 2 − L) mod T. The slave counter holds this value in the second cycle after the sync pulse. For example, T = 1000 and L = 4 give 998.
- R6: A lag equal to or greater than the active period is used as T−1.
- R7: The period and all lags are sampled only when the enable input first starts the master and at the edge where the master count wraps from T−1 to 0. Changes between those points have no effect on any output until then.
- R8: After enable, a slave output stays low until that slave's first reload.
- R9: When the enable input is sampled low, every output is low from the next cycle on, and all counters return to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run enable; low holds all channels idle |
| period_i | input | CNT_W | Requested period T in clock cycles |
| lag_i | input | NUM_SLV*CNT_W | Per-slave lag in cycles; slave n uses bits [n*CNT_W +: CNT_W] |
| pwm_master_o | output | 1 | Reference PWM waveform |
| pwm_slave_o | output | NUM_SLV | Lagging PWM waveforms, bit n for slave n |
| sync_o | output | 1 | One-cycle pulse at master count zero |

## Verification
The hardest situations to reach from the ports are a period change at a wrap boundary, a lag at the very end of the range, and a lag beyond it. In the first case the slave counters wrap on the new period for two cycles before their reload lands. In the second and third, the slave edge sits one cycle before the next master edge. The stimulus rewrites the period and all lags at arbitrary mid-period cycles, including an odd period. It programs lags of 0, T−1 and an out-of-range value, and repeats this at the full 1000-cycle period. A behavioural model compares every output on every clock. A separate edge-timing monitor measures each slave rise against the latest master rise once a configuration has settled.

// File: rtl/phased_pwm_pkg.sv
package phased_pwm_pkg;

  // Run state shared by the master and slave channels
  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_e;

  // Clock cycles from the master's zero count until a slave counter holds its load value
  localparam int unsigned SYNC_LAT_DEF = 2;

endpackage

// File: rtl/pwm_master_chan.sv
module pwm_master_chan
  import phased_pwm_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_SLV = 4,
  parameter int unsigned MIN_PER = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic [CNT_W-1:0]         period_i,
  input  logic [NUM_SLV*CNT_W-1:0] lag_i,
  output logic [CNT_W-1:0]         per_o,
  output logic [NUM_SLV*CNT_W-1:0] lag_o,
  output logic                     sync_o,
  output logic                     pwm_o
);

  localparam logic [CNT_W-1:0] PMIN = CNT_W'(MIN_PER);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  ch_state_e                state_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [CNT_W-1:0]         per_q;
  logic [NUM_SLV*CNT_W-1:0] lag_q;
  logic [CNT_W-1:0]         per_clamped;
  logic                     running;
  logic                     at_wrap;

  assign running     = (state_q == CH_RUN);
  assign per_clamped = (period_i < PMIN) ? PMIN : period_i;
  assign at_wrap     = running && (cnt_q >= per_q - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
      per_q   <= PMIN;
      lag_q   <= '0;
    end else if (!en_i) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
    end else if (!running || at_wrap) begin
      // shadow capture: start of run or period boundary only
      state_q <= CH_RUN;
      cnt_q   <= '0;
      per_q   <= per_clamped;
      lag_q   <= lag_i;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign per_o  = per_q;
  assign lag_o  = lag_q;
  assign sync_o = running && (cnt_q == '0);
  assign pwm_o  = running && (cnt_q < (per_q >> 1));

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q < per_q));

  assert_sync_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o);

  assert_idle_after_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!sync_o && !pwm_o));

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !at_wrap && en_i) |=> $stable(per_q));

endmodule

// File: rtl/pwm_phase_calc.sv
module pwm_phase_calc #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SYNC_LAT = 2
) (
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] lag_i,
  output logic [CNT_W-1:0] load_o
);

  localparam int unsigned XW = CNT_W + 1;

  logic [CNT_W-1:0] lag_eff;
  logic [XW-1:0]    sum;
  logic [XW-1:0]    per_x;

  always_comb begin
    // out-of-range lag saturates at the last count of the period
    lag_eff = (lag_i >= per_i) ? (per_i - CNT_W'(1)) : lag_i;
    per_x   = XW'(per_i);
    sum     = per_x + XW'(SYNC_LAT) - XW'(lag_eff);
    // period exceeds SYNC_LAT, so one subtraction completes the wrap
    load_o  = (sum >= per_x) ? CNT_W'(sum - per_x) : CNT_W'(sum);
  end

endmodule

// File: rtl/pwm_slave_chan.sv
module pwm_slave_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             pwm_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      armed_q <= 1'b1;
    end else if (armed_q) begin
      cnt_q <= (cnt_q >= per_i - ONE) ? '0 : cnt_q + ONE;
    end
  end

  assign pwm_o = armed_q && (cnt_q < (per_i >> 1));

  assert_load_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (load_val_i < per_i));

  assert_load_applies_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && en_i) |=> (cnt_q == $past(load_val_i)));

  assert_slave_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pwm_o);

endmodule

// File: rtl/phased_pwm_array.sv
module phased_pwm_array
  import phased_pwm_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NUM_SLV  = 4,
  parameter int unsigned SYNC_LAT = SYNC_LAT_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic [CNT_W-1:0]         period_i,
  input  logic [NUM_SLV*CNT_W-1:0] lag_i,
  output logic                     pwm_master_o,
  output logic [NUM_SLV-1:0]       pwm_slave_o,
  output logic                     sync_o
);

  // smallest period that keeps the latency correction a single wrap
  localparam int unsigned MIN_PER = SYNC_LAT + 1;
  localparam int unsigned DLY_N   = SYNC_LAT - 1;

  logic [CNT_W-1:0]         per_act;
  logic [NUM_SLV*CNT_W-1:0] lag_act;
  logic                     sync_w;
  logic [DLY_N-1:0]         dly_q;
  logic                     slave_load;

  pwm_master_chan #(
    .CNT_W  (CNT_W),
    .NUM_SLV(NUM_SLV),
    .MIN_PER(MIN_PER)
  ) u_master (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .period_i(period_i),
    .lag_i   (lag_i),
    .per_o   (per_act),
    .lag_o   (lag_act),
    .sync_o  (sync_w),
    .pwm_o   (pwm_master_o)
  );

  // sync delay line; the slave counter register is the final stage
  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      dly_q <= '0;
    end else begin
      dly_q[0] <= sync_w;
      for (int s = 1; s < int'(DLY_N); s++) begin
        dly_q[s] <= dly_q[s-1];
      end
    end
  end

  assign slave_load = dly_q[DLY_N-1];
  assign sync_o     = sync_w;

  for (genvar g = 0; g < NUM_SLV; g++) begin : g_slave
    logic [CNT_W-1:0] load_val;

    pwm_phase_calc #(
      .CNT_W   (CNT_W),
      .SYNC_LAT(SYNC_LAT)
    ) u_calc (
      .per_i (per_act),
      .lag_i (lag_act[g*CNT_W +: CNT_W]),
      .load_o(load_val)
    );

    pwm_slave_chan #(
      .CNT_W(CNT_W)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (en_i),
      .per_i     (per_act),
      .load_i    (slave_load),
      .load_val_i(load_val),
      .pwm_o     (pwm_slave_o[g])
    );
  end

  assert_reload_follows_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_w && en_i) |=> slave_load);

endmodule

// File: tb/phased_pwm_array_tb.sv
module phased_pwm_array_tb;

  localparam int CW = 16;
  localparam int NS = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           en = 1'b0;
  logic [CW-1:0]  period = 16'd20;
  logic [NS*CW-1:0] lags = '0;
  logic           pwm_m;
  logic [NS-1:0]  pwm_s;
  logic           sync;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  string cur_tag = "R1";
  bit checking = 1'b0;

  always #5 clk = ~clk;

  phased_pwm_array #(.CNT_W(CW), .NUM_SLV(NS)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .period_i    (period),
    .lag_i       (lags),
    .pwm_master_o(pwm_m),
    .pwm_slave_o (pwm_s),
    .sync_o      (sync)
  );

  // ---------------- behavioural reference model ----------------
  int m_run, m_mc, m_T, m_s1;
  int m_lag [NS];
  int m_sc  [NS];
  int m_arm [NS];

  function automatic int clamp_per(int p);
    return (p < 3) ? 3 : p;
  endfunction

  function automatic int eff_lag(int t, int l);
    return (l >= t) ? t - 1 : l;   // R6 saturation
  endfunction

  // R5: value held by the slave counter two cycles after the sync pulse
  function automatic int load_of(int t, int l);
    return (t + 2 - eff_lag(t, l)) % t;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_mc = 0; m_T = 3; m_s1 = 0;
      for (int i = 0; i < NS; i++) begin m_lag[i] = 0; m_sc[i] = 0; m_arm[i] = 0; end
    end else if (!en) begin
      m_run = 0; m_mc = 0; m_s1 = 0;
      for (int i = 0; i < NS; i++) begin m_sc[i] = 0; m_arm[i] = 0; end
    end else begin
      int sync_old;
      sync_old = (m_run != 0 && m_mc == 0) ? 1 : 0;
      for (int i = 0; i < NS; i++) begin
        if (m_s1 != 0) begin
          m_sc[i] = load_of(m_T, m_lag[i]);
          m_arm[i] = 1;
        end else if (m_arm[i] != 0) begin
          m_sc[i] = (m_sc[i] >= m_T - 1) ? 0 : m_sc[i] + 1;
        end
      end
      m_s1 = sync_old;
      if (m_run == 0 || m_mc >= m_T - 1) begin
        m_run = 1; m_mc = 0; m_T = clamp_per(int'(period));
        for (int i = 0; i < NS; i++) m_lag[i] = int'(lags[i*CW +: CW]);
      end else begin
        m_mc = m_mc + 1;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s at cycle %0d: actual %0d expected %0d",
               req, cur_tag, what, cyc, act, exp);
    end
  endtask

  // ---------------- per-cycle comparison and edge timing ----------------
  int prev_T = -1;
  int prev_lag [NS];
  int settle = 0;
  int last_mrise = 0;
  logic prev_m = 1'b0;
  logic [NS-1:0] prev_s = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n && checking) begin
      int exp_s;
      check("R3", "sync_o", int'(sync), (m_run != 0 && m_mc == 0) ? 1 : 0);
      check("R2", "pwm_master_o", int'(pwm_m), (m_run != 0 && m_mc < m_T / 2) ? 1 : 0);
      for (int i = 0; i < NS; i++) begin
        exp_s = (m_arm[i] != 0 && m_sc[i] < m_T / 2) ? 1 : 0;
        check("R4", $sformatf("pwm_slave_o[%0d]", i), int'(pwm_s[i]), exp_s);
      end
      // settle tracking: restart when the latched configuration changes (R7)
      begin
        bit changed;
        changed = (m_T != prev_T);
        for (int i = 0; i < NS; i++) if (m_lag[i] != prev_lag[i]) changed = 1'b1;
        if (changed || m_run == 0) settle = 0;
        prev_T = m_T;
        for (int i = 0; i < NS; i++) prev_lag[i] = m_lag[i];
      end
      if (pwm_m && !prev_m) begin
        settle++;
        last_mrise = cyc;
      end
      for (int i = 0; i < NS; i++) begin
        if (pwm_s[i] && !prev_s[i] && settle >= 2)
          check("R4", $sformatf("slave %0d rise delay cycles", i),
                cyc - last_mrise, eff_lag(m_T, m_lag[i]));
      end
    end
    prev_m = pwm_m;
    prev_s = pwm_s;
  end

  task automatic set_lags(input int a, input int b, input int c, input int d);
    lags = {CW'(d), CW'(c), CW'(b), CW'(a)};
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NS; i++) prev_lag[i] = 0;
    repeat (4) @(negedge clk);
    // R1: outputs low under reset
    check("R1", "reset pwm_master_o", int'(pwm_m), 0);
    check("R1", "reset sync_o", int'(sync), 0);
    check("R1", "reset pwm_slave_o", int'(pwm_s), 0);
    rst_n = 1'b1;
    checking = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "disabled sync_o", int'(sync), 0);

    // start: T=20, lags 0,4,7,19 (lag 0 and T-1 corners), R8 startup
    cur_tag = "R8";
    set_lags(0, 4, 7, 19);
    en = 1'b1;
    @(negedge clk);
    check("R1", "first running cycle sync_o", int'(sync), 1);
    repeat (120) @(negedge clk);

    // mid-period reprogramming with a shorter period and out-of-range lag
    cur_tag = "R7";
    repeat (7) @(negedge clk);
    period = 16'd16;
    set_lags(1, 2, 10, 25);
    cur_tag = "R6";
    repeat (120) @(negedge clk);

    // odd period
    cur_tag = "R2";
    repeat (3) @(negedge clk);
    period = 16'd15;
    set_lags(3, 14, 0, 8);
    repeat (100) @(negedge clk);

    // disable, then full-size period
    cur_tag = "R9";
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9", "disabled pwm_master_o", int'(pwm_m), 0);
    check("R9", "disabled pwm_slave_o", int'(pwm_s), 0);
    repeat (8) @(negedge clk);

    cur_tag = "R5";
    period = 16'd1000;
    set_lags(4, 500, 999, 0);
    en = 1'b1;
    repeat (3500) @(negedge clk);

    // period below minimum is clamped to 3
    cur_tag = "R2";
    period = 16'd1;
    set_lags(0, 1, 2, 5);
    repeat (1100) @(negedge clk);

    checking = 1'b0;
    finish_run();
  end

endmodule